// File: doc/BRIEF.md
# Redundant Boot Image Locator

This sequencer finds a usable boot image on a block storage card and then hands control to it. After a start pulse it checks that a card is present and of a bootable type. It then reads a signature word at a fixed offset inside a candidate window. When the signature matches, it reads four header words: the source address, the destination address, the code length and the execution start address. Next it walks a list of 8-byte configuration entries until one carries the end flag. Finally it asks an external engine to move the user code, and when that move completes it strobes a jump request together with the execution address.

A candidate can fail because its signature does not match, or because any read belonging to it (signature, header, configuration entries, or the code move itself) reports a CRC error. When a candidate fails, the sequencer moves its window forward by a fixed 0x200 bytes, whatever block size the card uses, and tries again. It tries at most 24 candidates.

Some conditions cannot be recovered: the candidates are used up, a response times out, no card is present, the card type is unsupported, or the entry walk reaches the source address without seeing an end flag. Each of these drops the storage enable, raises a hardware reset request and records a cause code. These outputs hold until the next reset.

Top module: `boot_locator`

## Requirements
- R1: Out of reset, `rd_req`, `host_en`, `hreset_req`, `go`, `xfer_start` and `cfg_valid` are low and `fail_cause` is 0 (none).
- R2: A start with `card_present` low ends in cause 3 (no card) without any read request, even when `card_type_ok` is also low.
- R3: A start with a card present but `card_type_ok` low ends in cause 4 (unsupported type) without any read request.
- R4: After i failed candidates, the signature read is issued at byte address 0x40 + i*0x200, and the word must equal the parameter `SIG_WORD`.
- R5: A signature mismatch, or a CRC error on any read of the current candidate, abandons that candidate and restarts at the next 0x200 window.
- R6: When the 24th candidate fails, the block ends in cause 1 (candidates exhausted) after exactly 24 signature reads.
- R7: After a good signature at window base B, the words at B+0x44, B+0x48, B+0x4C and B+0x50 are taken as source, destination, length and execution address. Configuration entry k is read as two words at B+0x54+8k and B+0x58+8k. Bit 0 of the first word is the end flag. Each entry read without error gives one `cfg_valid` pulse carrying the first word with bit 0 cleared, together with the second word.
- R8: If an entry address is at or above the latched source address before any entry with the end flag has been read, the block ends in cause 5 (no end flag).
- R9: A read or code move that is still unanswered after `TMO_CYC` cycles of waiting ends in cause 2 (timeout). A response arriving in the last allowed cycle is accepted.
- R10: After the end-flag entry, `xfer_start` pulses for one cycle with the latched source, destination and length. A clean `xfer_done` leads to a one-cycle `go` pulse with `exec_addr` set. A `xfer_done` carrying `xfer_crc_err` fails the candidate instead.
- R11: In any fatal state `host_en` is low, `hreset_req` is high and `fail_cause` is stable until reset, and a later start pulse is ignored.
- R12: `rd_req` stays high with an unchanged `rd_addr` until `rd_ack` arrives, with one read outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin the search (taken only when idle) |
| card_present | input | 1 | A card is inserted |
| card_type_ok | input | 1 | The inserted card is a bootable type |
| host_en | output | 1 | Storage interface enable |
| rd_req | output | 1 | Read request, held until acknowledged |
| rd_addr | output | ADDR_W | Byte address of the requested word |
| rd_ack | input | 1 | Read response valid |
| rd_data | input | 32 | Read response word |
| rd_crc_err | input | 1 | CRC error flag for this response |
| cfg_valid | output | 1 | One configuration entry delivered |
| cfg_addr | output | 32 | Entry first word with end flag cleared |
| cfg_data | output | 32 | Entry second word |
| xfer_start | output | 1 | One-cycle request to move the user code |
| xfer_src | output | ADDR_W | Card source address of the code |
| xfer_dst | output | ADDR_W | Destination address of the code |
| xfer_len | output | 32 | Code length |
| xfer_done | input | 1 | Code move complete |
| xfer_crc_err | input | 1 | CRC error seen during the code move |
| go | output | 1 | One-cycle jump strobe |
| exec_addr | output | ADDR_W | Execution start address |
| hreset_req | output | 1 | Hardware reset request (sticky) |
| fail_cause | output | 3 | 0 none, 1 exhausted, 2 timeout, 3 no card, 4 bad type, 5 no end flag |

## Verification
The assertions assume a well-behaved responder. It raises `rd_ack` only while `rd_req` is high, at most once per request, and it raises `xfer_done` only after a `xfer_start` pulse. The bench card model answers only requests it can see at the falling edge. It drops its pending state on every acknowledge, and it keeps its response latency a scenario setting so that the timeout limit can be reached exactly or just missed. The code-move responder reacts only to a `xfer_start` it has observed. For each window the card contents are computed arithmetically from the window index, which lets the bench predict every address, header field and entry value.

// File: rtl/boot_loc_pkg.sv
// Shared encodings for the boot image locator.
package boot_loc_pkg;

    // Sequencer states.
    typedef enum logic [3:0] {
        ST_IDLE, ST_SIG, ST_SRC, ST_DST, ST_LEN, ST_EXE,
        ST_CFG_CHK, ST_CFG_A, ST_CFG_D, ST_XREQ, ST_XWAIT,
        ST_GO, ST_DONE, ST_NEXT, ST_FAIL
    } loc_state_e;

    // Fatal cause codes as seen on fail_cause.
    typedef enum logic [2:0] {
        CAUSE_NONE     = 3'd0,
        CAUSE_EXHAUST  = 3'd1,
        CAUSE_TIMEOUT  = 3'd2,
        CAUSE_NO_CARD  = 3'd3,
        CAUSE_BAD_TYPE = 3'd4,
        CAUSE_NO_EC    = 3'd5
    } loc_cause_e;

endpackage

// File: rtl/boot_loc_attempt.sv
// Candidate window tracker.
// Counts failed candidates and keeps the running window base, which moves by
// STRIDE on each bump. Flags the last allowed candidate. Assumes that clr is
// asserted while idle, before a new search begins.
module boot_loc_attempt #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned MAX_TRY = 24,
    parameter int unsigned STRIDE  = 512,
    parameter int unsigned TRY_W   = $clog2(MAX_TRY + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              bump,
    output logic [ADDR_W-1:0] base,
    output logic              last
);

    logic [TRY_W-1:0] fails;

    // Advance the failure count and window base together.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            fails <= '0;
            base  <= '0;
        end else if (bump && !last) begin
            fails <= fails + 1'b1;
            base  <= base + ADDR_W'(STRIDE);
        end
    end

    // Last candidate reached when MAX_TRY-1 have failed.
    always_comb last = (fails == TRY_W'(MAX_TRY - 1));

    assert_fail_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fails < TRY_W'(MAX_TRY));

    assert_stride_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bump && !last && !clr) |=> (base == $past(base) + ADDR_W'(STRIDE)));

endmodule

// File: rtl/boot_loc_timer.sv
// Response watchdog.
// Counts the cycles spent waiting while arm is high and no hit arrives.
// Signals expiry in the LIMIT-th waiting cycle. A hit in that same cycle
// wins over expiry. Assumes that the user leaves the waiting state on
// expiry or on a hit.
module boot_loc_timer #(
    parameter int unsigned LIMIT = 1024,
    parameter int unsigned CW    = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic hit,
    output logic expired
);

    logic [CW-1:0] cnt;

    // Clear on every response or idle cycle, otherwise count up to the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !arm || hit) begin
            cnt <= '0;
        end else if (cnt != CW'(LIMIT - 1)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Expiry when the final allowed cycle passes without a response.
    always_comb expired = arm && !hit && (cnt == CW'(LIMIT - 1));

    assert_tmo_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(LIMIT - 1));

endmodule

// File: rtl/boot_locator.sv
// Redundant boot image locator sequencer.
// Searches candidate windows spaced STRIDE bytes apart for SIG_WORD. For a
// matching window it latches the header, walks the configuration entries
// until the end flag, starts the code move and strobes go. Recoverable
// failures advance the window. Fatal ones drop host_en and raise a sticky
// hreset_req with a cause code. Assumes one rd_ack per request, given only
// while rd_req is high, and that xfer_done only follows xfer_start.
module boot_locator
    import boot_loc_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned MAX_TRY  = 24,
    parameter int unsigned STRIDE   = 512,
    parameter int unsigned SIG_OFF  = 64,
    parameter int unsigned TMO_CYC  = 1024,
    parameter logic [31:0] SIG_WORD = 32'h5A1C_0B07
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              card_present,
    input  logic              card_type_ok,
    output logic              host_en,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [31:0]       rd_data,
    input  logic              rd_crc_err,
    output logic              cfg_valid,
    output logic [31:0]       cfg_addr,
    output logic [31:0]       cfg_data,
    output logic              xfer_start,
    output logic [ADDR_W-1:0] xfer_src,
    output logic [ADDR_W-1:0] xfer_dst,
    output logic [31:0]       xfer_len,
    input  logic              xfer_done,
    input  logic              xfer_crc_err,
    output logic              go,
    output logic [ADDR_W-1:0] exec_addr,
    output logic              hreset_req,
    output logic [2:0]        fail_cause
);

    localparam int unsigned WB      = 4;                  // bytes per word
    localparam int unsigned CFG_OFF = SIG_OFF + 5 * WB;   // after sig + 4 header words
    localparam int unsigned ENT_B   = 2 * WB;             // bytes per entry
    localparam int unsigned TRY_W   = $clog2(MAX_TRY + 1);

    loc_state_e        state;
    logic [ADDR_W-1:0] base;
    logic              last_try;
    logic [ADDR_W-1:0] cfg_ptr;
    logic [31:0]       ctrl_q;
    logic              tmo_expired;
    logic              wait_arm;
    logic              wait_hit;

    boot_loc_attempt #(
        .ADDR_W (ADDR_W),
        .MAX_TRY(MAX_TRY),
        .STRIDE (STRIDE),
        .TRY_W  (TRY_W)
    ) u_attempt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (state == ST_IDLE),
        .bump (state == ST_NEXT),
        .base (base),
        .last (last_try)
    );

    // Read request is a level for every read state.
    always_comb rd_req = (state == ST_SIG) || (state == ST_SRC) || (state == ST_DST) ||
                         (state == ST_LEN) || (state == ST_EXE) ||
                         (state == ST_CFG_A) || (state == ST_CFG_D);

    // Waiting covers reads and the code move.
    always_comb wait_arm = rd_req || (state == ST_XWAIT);
    always_comb wait_hit = (rd_req && rd_ack) || ((state == ST_XWAIT) && xfer_done);

    boot_loc_timer #(
        .LIMIT(TMO_CYC)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (wait_arm),
        .hit    (wait_hit),
        .expired(tmo_expired)
    );

    // Read address selected by the current step.
    always_comb begin
        case (state)
            ST_SRC:   rd_addr = base + ADDR_W'(SIG_OFF + 1 * WB);
            ST_DST:   rd_addr = base + ADDR_W'(SIG_OFF + 2 * WB);
            ST_LEN:   rd_addr = base + ADDR_W'(SIG_OFF + 3 * WB);
            ST_EXE:   rd_addr = base + ADDR_W'(SIG_OFF + 4 * WB);
            ST_CFG_A: rd_addr = cfg_ptr;
            ST_CFG_D: rd_addr = cfg_ptr + ADDR_W'(WB);
            default:  rd_addr = base + ADDR_W'(SIG_OFF);
        endcase
    end

    // Strobes and enable decoded from state.
    always_comb xfer_start = (state == ST_XREQ);
    always_comb go         = (state == ST_GO);
    always_comb host_en    = (state != ST_IDLE) && (state != ST_FAIL);

    // Main sequencer: steps, latches and fatal capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            xfer_src   <= '0;
            xfer_dst   <= '0;
            xfer_len   <= '0;
            exec_addr  <= '0;
            cfg_ptr    <= '0;
            ctrl_q     <= '0;
            cfg_valid  <= 1'b0;
            cfg_addr   <= '0;
            cfg_data   <= '0;
            hreset_req <= 1'b0;
            fail_cause <= CAUSE_NONE;
        end else begin
            cfg_valid <= 1'b0;
            if (tmo_expired) begin
                state      <= ST_FAIL;
                hreset_req <= 1'b1;
                fail_cause <= CAUSE_TIMEOUT;
            end else begin
                case (state)
                    ST_IDLE: if (start) begin
                        if (!card_present) begin
                            state      <= ST_FAIL;
                            hreset_req <= 1'b1;
                            fail_cause <= CAUSE_NO_CARD;
                        end else if (!card_type_ok) begin
                            state      <= ST_FAIL;
                            hreset_req <= 1'b1;
                            fail_cause <= CAUSE_BAD_TYPE;
                        end else begin
                            state <= ST_SIG;
                        end
                    end
                    ST_SIG: if (rd_ack) begin
                        state <= (rd_crc_err || rd_data != SIG_WORD) ? ST_NEXT : ST_SRC;
                    end
                    ST_SRC: if (rd_ack) begin
                        state    <= rd_crc_err ? ST_NEXT : ST_DST;
                        xfer_src <= ADDR_W'(rd_data);
                    end
                    ST_DST: if (rd_ack) begin
                        state    <= rd_crc_err ? ST_NEXT : ST_LEN;
                        xfer_dst <= ADDR_W'(rd_data);
                    end
                    ST_LEN: if (rd_ack) begin
                        state    <= rd_crc_err ? ST_NEXT : ST_EXE;
                        xfer_len <= rd_data;
                    end
                    ST_EXE: if (rd_ack) begin
                        state     <= rd_crc_err ? ST_NEXT : ST_CFG_CHK;
                        exec_addr <= ADDR_W'(rd_data);
                        cfg_ptr   <= base + ADDR_W'(CFG_OFF);
                    end
                    ST_CFG_CHK: begin
                        if (cfg_ptr >= xfer_src) begin
                            state      <= ST_FAIL;
                            hreset_req <= 1'b1;
                            fail_cause <= CAUSE_NO_EC;
                        end else begin
                            state <= ST_CFG_A;
                        end
                    end
                    ST_CFG_A: if (rd_ack) begin
                        state  <= rd_crc_err ? ST_NEXT : ST_CFG_D;
                        ctrl_q <= rd_data;
                    end
                    ST_CFG_D: if (rd_ack) begin
                        if (rd_crc_err) begin
                            state <= ST_NEXT;
                        end else begin
                            cfg_valid <= 1'b1;
                            cfg_addr  <= {ctrl_q[31:1], 1'b0};
                            cfg_data  <= rd_data;
                            cfg_ptr   <= cfg_ptr + ADDR_W'(ENT_B);
                            state     <= ctrl_q[0] ? ST_XREQ : ST_CFG_CHK;
                        end
                    end
                    ST_XREQ:  state <= ST_XWAIT;
                    ST_XWAIT: if (xfer_done) begin
                        state <= xfer_crc_err ? ST_NEXT : ST_GO;
                    end
                    ST_GO:    state <= ST_DONE;
                    ST_NEXT: begin
                        if (last_try) begin
                            state      <= ST_FAIL;
                            hreset_req <= 1'b1;
                            fail_cause <= CAUSE_EXHAUST;
                        end else begin
                            state <= ST_SIG;
                        end
                    end
                    default: state <= state;
                endcase
            end
        end
    end

    assert_addr_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack && !tmo_expired) |=> (rd_req && $stable(rd_addr)));

    assert_fatal_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hreset_req |=> (hreset_req && !host_en && $stable(fail_cause)));

    assert_fatal_no_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hreset_req |-> (!rd_req && !go && !xfer_start));

    assert_go_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (!go && !rd_req));

    assert_xfer_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start);

    assert_cfg_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> $past(rd_ack && !rd_crc_err));

endmodule

// File: tb/boot_locator_tb.sv
// Self-checking bench: arithmetic card model, code-move responder, scenario sweep.
module boot_locator_tb;

    localparam int unsigned TMO  = 16;
    localparam int unsigned TRYS = 24;
    localparam logic [31:0] SIG  = 32'h5A1C_0B07;
    localparam logic [31:0] NO_ADDR = 32'hFFFF_FFFF;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, start, card_present, card_type_ok;
    logic        host_en, rd_req, rd_ack, rd_crc_err;
    logic [31:0] rd_addr, rd_data;
    logic        cfg_valid;
    logic [31:0] cfg_addr, cfg_data;
    logic        xfer_start, xfer_done, xfer_crc_err;
    logic [31:0] xfer_src, xfer_dst, xfer_len;
    logic        go, hreset_req;
    logic [31:0] exec_addr;
    logic [2:0]  fail_cause;

    boot_locator #(.TMO_CYC(TMO), .MAX_TRY(TRYS), .SIG_WORD(SIG)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .card_present(card_present),
        .card_type_ok(card_type_ok), .host_en(host_en), .rd_req(rd_req),
        .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data), .rd_crc_err(rd_crc_err),
        .cfg_valid(cfg_valid), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .xfer_start(xfer_start), .xfer_src(xfer_src), .xfer_dst(xfer_dst),
        .xfer_len(xfer_len), .xfer_done(xfer_done), .xfer_crc_err(xfer_crc_err),
        .go(go), .exec_addr(exec_addr), .hreset_req(hreset_req), .fail_cause(fail_cause)
    );

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    // Scenario settings.
    int good_slot, src_rel, n_cfg, lat, xlat, xbad_left;
    logic [31:0] crc_addr;
    bit mute, xmute;

    // Observations.
    int sig_reads, sig_addr_err, hold_err, reads_total, req_cycles, cfg_cnt, xfer_cnt, go_cnt;
    logic [31:0] last_exec, last_cfg_addr, last_cfg_data, last_xsrc, last_xdst, last_xlen;
    int lat_cnt, xcnt;
    bit xpend, req_pend;
    logic [31:0] pend_addr;

    // Card contents derived from the window index.
    function automatic logic [31:0] card_word(input logic [31:0] a);
        int slot, off, k;
        slot = int'(a >> 9);
        off  = int'(a & 32'h1FF);
        if (off == 'h40) return (slot >= good_slot) ? SIG : ~SIG;
        if (off == 'h44) return 32'(slot * 512 + src_rel);
        if (off == 'h48) return 32'h1000_0000 + 32'(slot);
        if (off == 'h4C) return 32'h0000_0100 + 32'(slot);
        if (off == 'h50) return 32'h2000_0000 + 32'(slot * 16);
        if (off >= 'h54) begin
            k = (off - 'h54) >> 3;
            if (((off - 'h54) & 4) == 0)
                return 32'(((k + 1) << 4) | (slot << 8) | ((k == n_cfg - 1) ? 1 : 0));
            return 32'hC0DE_0000 + 32'(k);
        end
        return 32'h0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Card responder, code-move responder and monitors, all at the falling edge.
    initial begin
        rd_ack = 0; rd_data = 0; rd_crc_err = 0; xfer_done = 0; xfer_crc_err = 0;
        lat_cnt = 0; xcnt = 0; xpend = 0; req_pend = 0; pend_addr = 0;
        forever begin
            @(negedge clk);
            rd_ack = 0; rd_crc_err = 0; xfer_done = 0; xfer_crc_err = 0;
            if (!rst_n) begin
                lat_cnt = 0; xpend = 0; req_pend = 0;
            end else begin
                if (rd_req) begin
                    req_cycles++;
                    if (req_pend && rd_addr != pend_addr) hold_err++;
                    if (!mute && lat_cnt == lat) begin
                        rd_ack = 1;
                        rd_data = card_word(rd_addr);
                        rd_crc_err = (rd_addr == crc_addr);
                        lat_cnt = 0; req_pend = 0; reads_total++;
                        if (rd_addr[8:0] == 9'h040) begin
                            if (rd_addr != 32'h40 + 32'(sig_reads * 512)) sig_addr_err++;
                            sig_reads++;
                        end
                    end else begin
                        lat_cnt++; req_pend = 1; pend_addr = rd_addr;
                    end
                end else begin
                    lat_cnt = 0; req_pend = 0;
                end
                if (cfg_valid) begin
                    cfg_cnt++; last_cfg_addr = cfg_addr; last_cfg_data = cfg_data;
                end
                if (go) begin
                    go_cnt++; last_exec = exec_addr;
                end
                if (xfer_start) begin
                    xfer_cnt++; xpend = 1; xcnt = 0;
                    last_xsrc = xfer_src; last_xdst = xfer_dst; last_xlen = xfer_len;
                end else if (xpend && !xmute) begin
                    if (xcnt == xlat) begin
                        xfer_done = 1;
                        xfer_crc_err = (xbad_left > 0);
                        if (xbad_left > 0) xbad_left--;
                        xpend = 0;
                    end else begin
                        xcnt++;
                    end
                end
            end
        end
    end

    task automatic do_reset();
        rst_n = 0; start = 0;
        repeat (2) @(posedge clk);
        #1;
        sig_reads = 0; sig_addr_err = 0; hold_err = 0; reads_total = 0; req_cycles = 0;
        cfg_cnt = 0; xfer_cnt = 0; go_cnt = 0;
        last_exec = 0; last_cfg_addr = 0; last_cfg_data = 0;
        last_xsrc = 0; last_xdst = 0; last_xlen = 0;
        @(negedge clk);
        rst_n = 1;
    endtask

    task automatic set_case(input int gs, input int sr, input int nc, input int l);
        good_slot = gs; src_rel = sr; n_cfg = nc; lat = l;
        xlat = 1; xbad_left = 0; crc_addr = NO_ADDR; mute = 0; xmute = 0;
        card_present = 1; card_type_ok = 1;
    endtask

    // Pulse start and wait for go or a fatal request; returns the cycle count.
    task automatic run_start(output int cyc);
        cyc = 0;
        @(negedge clk);
        start = 1;
        for (int c = 1; c <= 8000; c++) begin
            @(negedge clk);
            if (c == 1) start = 0;
            if (go_cnt > 0 || hreset_req) begin
                cyc = c;
                break;
            end
        end
        if (cyc == 0) chk("hang", 32'd0, 32'd1);
        repeat (3) @(negedge clk);
    endtask

    task automatic check_ok(input int s, input int exp_sig, input int exp_cfg);
        chk("R10 go count", 32'(go_cnt), 32'd1);
        chk("R10 exec addr", last_exec, 32'h2000_0000 + 32'(s * 16));
        chk("R7 xfer src", last_xsrc, 32'(s * 512 + src_rel));
        chk("R7 xfer dst", last_xdst, 32'h1000_0000 + 32'(s));
        chk("R7 xfer len", last_xlen, 32'h100 + 32'(s));
        chk("R7 last cfg addr", last_cfg_addr, 32'((n_cfg << 4) | (s << 8)));
        chk("R7 last cfg data", last_cfg_data, 32'hC0DE_0000 + 32'(n_cfg - 1));
        chk("R4 sig addresses", 32'(sig_addr_err), 32'd0);
        chk("R12 addr hold", 32'(hold_err), 32'd0);
        chk("R11 no reset req", {31'd0, hreset_req}, 32'd0);
        if (exp_sig >= 0) chk("R5 sig reads", 32'(sig_reads), 32'(exp_sig));
        if (exp_cfg >= 0) chk("R7 cfg count", 32'(cfg_cnt), 32'(exp_cfg));
    endtask

    task automatic check_fatal(input string tag, input logic [2:0] cause);
        chk({tag, " cause"}, {29'd0, fail_cause}, {29'd0, cause});
        chk({tag, " R11 reset req"}, {31'd0, hreset_req}, 32'd1);
        chk({tag, " R11 host_en low"}, {31'd0, host_en}, 32'd0);
        chk({tag, " no go"}, 32'(go_cnt), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int cyc;
        set_case(0, 'h1F0, 1, 0);
        do_reset();
        // R1 reset state
        chk("R1 rd_req", {31'd0, rd_req}, 32'd0);
        chk("R1 host_en", {31'd0, host_en}, 32'd0);
        chk("R1 hreset_req", {31'd0, hreset_req}, 32'd0);
        chk("R1 fail_cause", {29'd0, fail_cause}, 32'd0);
        chk("R1 strobes", {29'd0, go, xfer_start, cfg_valid}, 32'd0);

        // R2 no card (priority over bad type)
        set_case(0, 'h1F0, 1, 0); card_present = 0; card_type_ok = 0;
        do_reset(); run_start(cyc);
        check_fatal("R2", 3'd3);
        chk("R2 no read", 32'(req_cycles), 32'd0);
        // R11 start ignored after a fatal exit
        card_present = 1; card_type_ok = 1;
        @(negedge clk); start = 1; @(negedge clk); start = 0;
        repeat (10) @(negedge clk);
        chk("R11 start ignored", 32'(req_cycles), 32'd0);
        check_fatal("R11 held", 3'd3);

        // R3 unsupported type
        set_case(0, 'h1F0, 1, 0); card_type_ok = 0;
        do_reset(); run_start(cyc);
        check_fatal("R3", 3'd4);
        chk("R3 no read", 32'(req_cycles), 32'd0);

        // R4 R5 R7 R10 sweep over the good window position
        for (int s = 0; s < int'(TRYS); s++) begin
            set_case(s, 'h1F0, 1 + s % 3, s % 3);
            do_reset(); run_start(cyc);
            check_ok(s, s + 1, 1 + s % 3);
        end

        // R6 no window valid
        set_case(99, 'h1F0, 1, 1);
        do_reset(); run_start(cyc);
        check_fatal("R6", 3'd1);
        chk("R6 sig reads", 32'(sig_reads), 32'(TRYS));
        chk("R4 sig addresses", 32'(sig_addr_err), 32'd0);

        // R6 last window lost to a CRC error
        set_case(23, 'h1F0, 1, 0); crc_addr = 32'(23 * 512 + 'h40);
        do_reset(); run_start(cyc);
        check_fatal("R6 crc", 3'd1);

        // R5 CRC on a good signature
        set_case(0, 'h1F0, 2, 0); crc_addr = 32'h40;
        do_reset(); run_start(cyc);
        check_ok(1, 2, 2);

        // R5 CRC on a header word
        set_case(2, 'h1F0, 1, 1); crc_addr = 32'(2 * 512 + 'h48);
        do_reset(); run_start(cyc);
        check_ok(3, 4, 1);

        // R5 CRC on the data word of entry 1
        set_case(0, 'h1F0, 2, 0); crc_addr = 32'h60;
        do_reset(); run_start(cyc);
        check_ok(1, 2, 3);

        // R10 CRC during the code move
        set_case(5, 'h1F0, 1, 0); xbad_left = 1;
        do_reset(); run_start(cyc);
        check_ok(6, 7, 2);
        chk("R10 xfer count", 32'(xfer_cnt), 32'd2);

        // R8 entries reach the source address without an end flag
        set_case(0, 'h6C, 0, 0);
        do_reset(); run_start(cyc);
        check_fatal("R8", 3'd5);
        chk("R8 entries read", 32'(cfg_cnt), 32'd3);

        // R8 source address at the first entry
        set_case(0, 'h54, 1, 0);
        do_reset(); run_start(cyc);
        check_fatal("R8 first", 3'd5);
        chk("R8 no entries", 32'(cfg_cnt), 32'd0);

        // R9 response in the last allowed cycle
        set_case(0, 'h1F0, 2, int'(TMO) - 1);
        do_reset(); run_start(cyc);
        check_ok(0, 1, 2);

        // R9 response one cycle too late
        set_case(0, 'h1F0, 1, int'(TMO));
        do_reset(); run_start(cyc);
        check_fatal("R9 late", 3'd2);

        // R9 silent card, exact expiry cycle
        set_case(0, 'h1F0, 1, 0); mute = 1;
        do_reset(); run_start(cyc);
        check_fatal("R9 mute", 3'd2);
        chk("R9 expiry cycle", 32'(cyc), 32'(TMO + 1));

        // R9 code move never completes
        set_case(0, 'h1F0, 1, 0); xmute = 1;
        do_reset(); run_start(cyc);
        check_fatal("R9 xfer", 3'd2);
        chk("R9 xfer started", 32'(xfer_cnt), 32'd1);

        // R12 long latency keeps the address
        set_case(1, 'h1F0, 3, 5);
        do_reset(); run_start(cyc);
        check_ok(1, 2, 3);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule